// File: doc/BRIEF.md
# CAN Bus-Mode Fault-Tolerance Sequencer

This block decides how a CAN node with two receive comparators and two transmit drivers uses the bus wires. It holds a two-bit bus mode. In the normal mode both wires are read differentially. When the protocol engine reports a failure, the mode steps to reading only one wire, then to reading only the other wire, and finally to a low-power sleep mode. In sleep mode a dominant level seen on either wire returns the node to the differential mode.

For each mode the block chooses which comparator flag forms the received bit. It also gates the two transmit drivers, and it stops the local oscillator while the node sleeps. Every change of mode raises a one-cycle pulse. This pulse clears the node's I/O registers and output enables, sets the reset-detected status flag and clears the error-warning flag. Because of this, a node that loses contact with its host falls back to floating outputs. The protocol engine, the error counters and the analog comparators sit outside this block. The block only receives their flags and overflow pulses.

Top module: `canbm_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `bus_mode` is 3 (sleep). In that state `tx0_en`, `tx1_en`, `osc_run`, `io_clr`, `rstd_set` and `ew_clr` are 0 and `rx_bit` is 1 (recessive).
- R2: The mode codes on `bus_mode` are 0 = differential, 1 = single wire on receive input 1, 2 = single wire on receive input 0, and 3 = sleep. `tx0_en` is 1 in modes 0, 1 and 2. `tx1_en` is 1 only in modes 0 and 1.
- R3: In modes 0, 1 and 2, a cycle with `bit_ovf` or `tec_ovf` high moves `bus_mode` to the old value plus one on the next clock edge.
- R4: In mode 3, `bit_ovf` and `tec_ovf` have no effect. The mode never wraps from 3 to 0 because of them.
- R5: In mode 3, a cycle with `rx0_gt_ref` low or `rx1_gt_ref` high moves `bus_mode` to 0 on the next edge. With `rx0_gt_ref` high and `rx1_gt_ref` low, the mode stays at 3.
- R6: In modes 0, 1 and 2, the wake levels on `rx0_gt_ref` and `rx1_gt_ref` never change the mode.
- R7: `rx_bit` (1 = recessive) follows the mode. In mode 0 it equals `rx0_gt_rx1`. In mode 1 it equals the inverse of `rx1_gt_ref`. In mode 2 it equals `rx0_gt_ref`. In mode 3 it is 1. With `RX_REG`=0 it follows the inputs in the same cycle. With `RX_REG`=1 it lags them by one cycle.
- R8: `io_clr` is high for exactly the first cycle after any mode change, and never at any other time.
- R9: `rstd_set` and `ew_clr` pulse in exactly the same cycles as `io_clr`.
- R10: `osc_run` is 1 in modes 0 to 2 and 0 in mode 3.
- R11: With no overflow pulse outside sleep, and no wake level inside sleep, `bus_mode` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx0_gt_rx1 | input | 1 | Comparator flag: receive input 0 above receive input 1 |
| rx0_gt_ref | input | 1 | Comparator flag: receive input 0 above reference |
| rx1_gt_ref | input | 1 | Comparator flag: receive input 1 above reference |
| bit_ovf | input | 1 | Single-cycle pulse: bit counter overflowed since last calibration |
| tec_ovf | input | 1 | Single-cycle pulse: transmit error counter passed bus-off limit |
| bus_mode | output | 2 | Current bus mode (0..3) |
| rx_bit | output | 1 | Received bit, 1 = recessive |
| tx0_en | output | 1 | Enable for transmit driver 0 |
| tx1_en | output | 1 | Enable for transmit driver 1 |
| osc_run | output | 1 | Oscillator run request |
| io_clr | output | 1 | One-cycle clear of I/O registers and output enables |
| rstd_set | output | 1 | One-cycle pulse setting the reset-detected status flag |
| ew_clr | output | 1 | One-cycle pulse clearing the error-warning status flag |

## Verification
The assertions check the mode-step rules on every cycle: the plus-one step on an overflow, the hold in sleep without a wake level, the wake to mode 0, the hold when nothing happens, and the rule that a clear pulse appears only after a real mode change. The bench scenarios are the only place where the comparator selection per mode is shown, together with the transmit and oscillator gating of each mode. They also show that the wake levels are ignored in active modes and that overflow pulses are ignored in sleep. Finally, they show the full escalation chain from differential mode down to sleep.

// File: rtl/canbm_pkg.sv
package canbm_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      BM_DIFF    = 2'd0,
      BM_ONE_RX1 = 2'd1,
      BM_ONE_RX0 = 2'd2,
      BM_SLEEP   = 2'd3
   } bus_mode_t;
endpackage

// File: rtl/canbm_mode_fsm.sv
module canbm_mode_fsm
   import canbm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fail_evt,
   input  logic      wake_evt,
   output bus_mode_t mode_q,
   output logic      chg_q
);
   bus_mode_t             mode_d;
   logic [MODE_W-1:0]     mode_inc;

   assign mode_inc = mode_q + MODE_W'(1);

   always_comb begin
      mode_d = mode_q;
      if (mode_q != BM_SLEEP) begin
         if (fail_evt) mode_d = bus_mode_t'(mode_inc);
      end else if (wake_evt) begin
         mode_d = BM_DIFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= BM_SLEEP;
         chg_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         chg_q  <= (mode_d != mode_q);
      end
   end

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != BM_SLEEP && fail_evt) |=> (mode_q == bus_mode_t'($past(mode_q) + 2'd1)));

   // R4
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BM_SLEEP && !wake_evt) |=> (mode_q == BM_SLEEP));

   // R5
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BM_SLEEP && wake_evt) |=> (mode_q == BM_DIFF));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != BM_SLEEP && !fail_evt) |=> $stable(mode_q));
endmodule

// File: rtl/canbm_rx_select.sv
module canbm_rx_select
   import canbm_pkg::*;
#(
   parameter int RX_REG = 0
)(
   input  logic      clk,
   input  logic      rst_n,
   input  bus_mode_t mode,
   input  logic      rx0_gt_rx1,
   input  logic      rx0_gt_ref,
   input  logic      rx1_gt_ref,
   output logic      rx_bit,
   output logic      wake_dom
);
   logic rx_sel;

   if (!(RX_REG inside {0, 1})) begin : g_bad_param
      $error("canbm_rx_select: RX_REG must be 0 or 1");
   end

   always_comb begin
      unique case (mode)
         BM_DIFF:    rx_sel = rx0_gt_rx1;
         BM_ONE_RX1: rx_sel = ~rx1_gt_ref;
         BM_ONE_RX0: rx_sel = rx0_gt_ref;
         default:    rx_sel = 1'b1;
      endcase
   end

   // dominant on either wire: input 0 below reference or input 1 above it
   assign wake_dom = ~rx0_gt_ref | rx1_gt_ref;

   if (RX_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rx_bit <= 1'b1;
         else        rx_bit <= rx_sel;
      end
   end else begin : g_comb
      assign rx_bit = rx_sel;
   end
endmodule

// File: rtl/canbm_drive_ctrl.sv
module canbm_drive_ctrl
   import canbm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  bus_mode_t mode,
   input  logic      chg,
   output logic      tx0_en,
   output logic      tx1_en,
   output logic      osc_run,
   output logic      io_clr,
   output logic      rstd_set,
   output logic      ew_clr
);
   always_comb begin
      tx0_en  = 1'b0;
      tx1_en  = 1'b0;
      osc_run = 1'b1;
      unique case (mode)
         BM_DIFF, BM_ONE_RX1: begin
            tx0_en = 1'b1;
            tx1_en = 1'b1;
         end
         BM_ONE_RX0: tx0_en = 1'b1;
         default:    osc_run = 1'b0;
      endcase
   end

   assign io_clr   = chg;
   assign rstd_set = chg;
   assign ew_clr   = chg;

   // R8
   clr_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_clr |-> (mode != $past(mode)));

   // R8
   change_gives_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> io_clr);
endmodule

// File: rtl/canbm_seq.sv
module canbm_seq
   import canbm_pkg::*;
#(
   parameter int RX_REG = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx0_gt_rx1,
   input  logic              rx0_gt_ref,
   input  logic              rx1_gt_ref,
   input  logic              bit_ovf,
   input  logic              tec_ovf,
   output logic [MODE_W-1:0] bus_mode,
   output logic              rx_bit,
   output logic              tx0_en,
   output logic              tx1_en,
   output logic              osc_run,
   output logic              io_clr,
   output logic              rstd_set,
   output logic              ew_clr
);
   bus_mode_t mode;
   logic      chg;
   logic      wake_dom;
   logic      fail_evt;

   assign fail_evt = bit_ovf | tec_ovf;

   canbm_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .fail_evt (fail_evt),
      .wake_evt (wake_dom),
      .mode_q   (mode),
      .chg_q    (chg)
   );

   canbm_rx_select #(.RX_REG(RX_REG)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .rx0_gt_rx1 (rx0_gt_rx1),
      .rx0_gt_ref (rx0_gt_ref),
      .rx1_gt_ref (rx1_gt_ref),
      .rx_bit     (rx_bit),
      .wake_dom   (wake_dom)
   );

   canbm_drive_ctrl u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .chg      (chg),
      .tx0_en   (tx0_en),
      .tx1_en   (tx1_en),
      .osc_run  (osc_run),
      .io_clr   (io_clr),
      .rstd_set (rstd_set),
      .ew_clr   (ew_clr)
   );

   assign bus_mode = mode;

   // R10
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == 2'd3) |-> (!osc_run && !tx0_en && !tx1_en));
endmodule

// File: tb/tb_canbm_seq.sv
module tb_canbm_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx0_gt_rx1 = 1'b1;
   logic       rx0_gt_ref = 1'b1;
   logic       rx1_gt_ref = 1'b0;
   logic       bit_ovf = 1'b0;
   logic       tec_ovf = 1'b0;
   logic [1:0] bus_mode;
   logic       rx_bit, tx0_en, tx1_en, osc_run, io_clr, rstd_set, ew_clr;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   canbm_seq dut (
      .clk(clk), .rst_n(rst_n),
      .rx0_gt_rx1(rx0_gt_rx1), .rx0_gt_ref(rx0_gt_ref), .rx1_gt_ref(rx1_gt_ref),
      .bit_ovf(bit_ovf), .tec_ovf(tec_ovf),
      .bus_mode(bus_mode), .rx_bit(rx_bit), .tx0_en(tx0_en), .tx1_en(tx1_en),
      .osc_run(osc_run), .io_clr(io_clr), .rstd_set(rstd_set), .ew_clr(ew_clr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle_wires();
      rx0_gt_ref = 1'b1;
      rx1_gt_ref = 1'b0;
   endtask

   task automatic check_mode_outs(input string req, input int m);
      chk(req, "bus_mode", bus_mode, m);
      chk("R2", "tx0_en", tx0_en, (m != 3));
      chk("R2", "tx1_en", tx1_en, (m < 2));
      chk("R10", "osc_run", osc_run, (m != 3));
   endtask

   task automatic fail_pulse(input bit use_tec);
      @(negedge clk);
      if (use_tec) tec_ovf = 1'b1; else bit_ovf = 1'b1;
      @(negedge clk);
      bit_ovf = 1'b0;
      tec_ovf = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle_wires();
      repeat (3) @(negedge clk);
      check_mode_outs("R1", 3);
      chk("R1", "io_clr", io_clr, 0);
      chk("R1", "rx_bit", rx_bit, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check_mode_outs("R1", 3);
      chk("R1", "io_clr after release", io_clr, 0);
   endtask

   task automatic t_sleep_hold();
      repeat (3) @(negedge clk);
      chk("R5", "no wake on recessive", bus_mode, 3);
      fail_pulse(1'b0);
      chk("R4", "bit_ovf ignored in sleep", bus_mode, 3);
      chk("R8", "no clr without change", io_clr, 0);
      fail_pulse(1'b1);
      chk("R4", "tec_ovf ignored in sleep", bus_mode, 3);
      chk("R7", "rx_bit sleep", rx_bit, 1);
   endtask

   task automatic t_wake(input bit via_rx1);
      @(negedge clk);
      if (via_rx1) rx1_gt_ref = 1'b1; else rx0_gt_ref = 1'b0;
      @(negedge clk);
      idle_wires();
      check_mode_outs("R5", 0);
      chk("R8", "io_clr on wake", io_clr, 1);
      chk("R9", "rstd_set on wake", rstd_set, 1);
      chk("R9", "ew_clr on wake", ew_clr, 1);
      @(negedge clk);
      chk("R8", "io_clr one cycle", io_clr, 0);
      chk("R9", "rstd_set one cycle", rstd_set, 0);
      chk("R11", "mode holds", bus_mode, 0);
   endtask

   task automatic t_rx_mode(input int m);
      @(negedge clk);
      rx0_gt_rx1 = 1'b1; rx0_gt_ref = 1'b1; rx1_gt_ref = 1'b0; #1;
      chk("R7", $sformatf("rx_bit mode%0d a", m), rx_bit, 1);
      case (m)
         0: begin rx0_gt_rx1 = 1'b0; #1; chk("R7", "mode0 dominant", rx_bit, 0);
                  rx0_gt_ref = 1'b0; rx1_gt_ref = 1'b1; rx0_gt_rx1 = 1'b1; #1;
                  chk("R7", "mode0 ignores ref flags", rx_bit, 1); end
         1: begin rx1_gt_ref = 1'b1; #1; chk("R7", "mode1 dominant", rx_bit, 0);
                  rx0_gt_rx1 = 1'b0; rx0_gt_ref = 1'b0; rx1_gt_ref = 1'b0; #1;
                  chk("R7", "mode1 ignores rx0 flags", rx_bit, 1); end
         default: begin rx0_gt_ref = 1'b0; #1; chk("R7", "mode2 dominant", rx_bit, 0);
                  rx0_gt_rx1 = 1'b0; rx1_gt_ref = 1'b1; rx0_gt_ref = 1'b1; #1;
                  chk("R7", "mode2 ignores rx1 flags", rx_bit, 1); end
      endcase
      // hold dominant wake levels for a few edges: must not matter outside sleep
      rx0_gt_ref = 1'b0; rx1_gt_ref = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6", $sformatf("wake ignored in mode%0d", m), bus_mode, m);
      chk("R8", "no clr while holding", io_clr, 0);
      idle_wires();
      rx0_gt_rx1 = 1'b1;
   endtask

   task automatic t_escalate(input int from_m, input bit use_tec);
      fail_pulse(use_tec);
      check_mode_outs("R3", from_m + 1);
      chk("R8", "io_clr on step", io_clr, 1);
      chk("R9", "ew_clr on step", ew_clr, 1);
      @(negedge clk);
      chk("R8", "io_clr drops", io_clr, 0);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_sleep_hold();
      t_wake(1'b0);
      t_rx_mode(0);
      t_escalate(0, 1'b0);
      t_rx_mode(1);
      t_escalate(1, 1'b1);
      t_rx_mode(2);
      t_escalate(2, 1'b0);
      t_sleep_hold();
      t_wake(1'b1);
      t_escalate(0, 1'b1);
      t_escalate(1, 1'b0);
      t_escalate(2, 1'b1);
      t_reset();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule